// File: doc/BRIEF.md
# Cluster-Buffered Dual-Address DMA Engine

This block is a single DMA channel. It copies a block of words from a source address to a destination address, one cluster at a time. Each cluster is a run of back-to-back reads that fill a small internal buffer, followed by a run of back-to-back writes that empty the buffer to the destination. The engine holds the system bus, with a lock output raised, for the whole cluster. It releases the bus between clusters, so other masters, refresh or bus-release cycles can only take the bus at cluster boundaries.

Software programs four registers through a word-wide register port:
- a source byte address;
- a destination byte address;
- a cluster count;
- a control word holding the cluster length, the end-pulse enable and a start bit.

Both addresses are kept inside the engine, so this is dual-address operation. With a cluster length of one access, the engine falls back to plain block-style copying: one read, then one write, per bus tenure. The engine drives no transfer-acknowledge output.

Top module: `clus_dma`

## Requirements
- R1: The cluster length is programmed in control-register field bits [6:4] as the number of accesses minus one. The range is 1 to 8 accesses of 4 bytes, so a cluster is 4 to 32 bytes. The field reads back as written.
- R2: Within a cluster, every read completes before the first write is issued. The writes then carry the read data in the same order, and their count equals the read count.
- R3: Each completed access advances its own address by 4 bytes. After each cluster, the source and destination registers (register indexes 0 and 1) read back the advanced addresses.
- R4: A cluster starts only after `bus_gnt_i` is seen with `bus_req_o` high. `bus_lock_o` stays high without a break from the first read to the acknowledge of the last write. A pending access holds its address and strobe until it is acknowledged.
- R5: When a cluster ends, the request and the lock both drop for at least one cycle before the next cluster requests the bus.
- R6: The count register (index 2) decrements once per cluster. The transfer ends after the cluster that brings it to zero, and the count register then reads zero.
- R7: If control bit 1 is set, `end_pulse_o` is high during the final write of the whole transfer and at no other time. If the bit is clear, `end_pulse_o` never rises.
- R8: Writing a 1 to control bit 0 starts a transfer. The busy flag (control bit 8) reads 1 from the cycle after start until completion. While busy, every register write, including a second start, is ignored.
- R9: A start with the count register at zero is ignored. Busy stays 0 and no bus request is made.
- R10: With a cluster length of one, each bus tenure holds exactly one read followed by one write.
- R11: After reset, all registers read zero and every bus output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register index (0 src, 1 dst, 2 count, 3 control) for read and write |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for `cfg_addr_i` |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_lock_o | output | 1 | Bus held for an indivisible cluster |
| mem_addr_o | output | 32 | Access byte address |
| mem_rd_o | output | 1 | Read access pending |
| mem_wr_o | output | 1 | Write access pending |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, taken with the acknowledge |
| mem_ack_i | input | 1 | Access completes this cycle |
| end_pulse_o | output | 1 | Final-write marker of the transfer |

## Verification
The bench aims first at the read-to-write handover inside a cluster. A design that started writing one beat early would put stale buffer data on the bus, or would show fewer reads than writes in one lock tenure. It also covers the one-access cluster and the full 32-byte cluster, where an off-by-one in the beat counter either drops the last word or overruns into the guard word past the destination. Random acknowledge and grant delays test whether the address and lock stay stable across wait states. The bench also pokes registers and start while busy, and starts with a zero count; a design that accepted either would show corrupted register readback or spurious bus requests.

// File: rtl/clus_dma_pkg.sv
package clus_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD,
    ST_WR,
    ST_REL
  } seq_st_e;

  localparam logic [1:0] REG_SRC = 2'd0;
  localparam logic [1:0] REG_DST = 2'd1;
  localparam logic [1:0] REG_CNT = 2'd2;
  localparam logic [1:0] REG_CTL = 2'd3;

  localparam int CTL_START = 0;
  localparam int CTL_ENDEN = 1;
  localparam int CTL_LEN   = 4;
  localparam int CTL_BUSY  = 8;
endpackage

// File: rtl/clus_dma_regs.sv
module clus_dma_regs
  import clus_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              wb_i,
  input  logic [ADDR_W-1:0] wb_src_i,
  input  logic [ADDR_W-1:0] wb_dst_i,
  input  logic [CNT_W-1:0]  wb_cnt_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [IDX_W-1:0]  len_m1_o,
  output logic              end_en_o,
  output logic              start_o
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  len_q;
  logic              end_en_q;
  logic              cfg_wr;

  assign cfg_wr  = we_i && !busy_i;
  assign start_o = cfg_wr && (addr_i == REG_CTL) && wdata_i[CTL_START] && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      len_q    <= '0;
      end_en_q <= 1'b0;
    end else if (wb_i) begin
      src_q <= wb_src_i;
      dst_q <= wb_dst_i;
      cnt_q <= wb_cnt_i;
    end else if (cfg_wr) begin
      unique case (addr_i)
        REG_SRC: src_q <= wdata_i[ADDR_W-1:0];
        REG_DST: dst_q <= wdata_i[ADDR_W-1:0];
        REG_CNT: cnt_q <= wdata_i[CNT_W-1:0];
        default: begin
          len_q    <= wdata_i[CTL_LEN +: IDX_W];
          end_en_q <= wdata_i[CTL_ENDEN];
        end
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_SRC: rdata_o = DATA_W'(src_q);
      REG_DST: rdata_o = DATA_W'(dst_q);
      REG_CNT: rdata_o = DATA_W'(cnt_q);
      default: begin
        rdata_o[CTL_ENDEN]         = end_en_q;
        rdata_o[CTL_LEN +: IDX_W]  = len_q;
        rdata_o[CTL_BUSY]          = busy_i;
      end
    endcase
  end

  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign cnt_o    = cnt_q;
  assign len_m1_o = len_q;
  assign end_en_o = end_en_q;
endmodule

// File: rtl/clus_dma_buf.sv
module clus_dma_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] ent_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (we_i && (idx_i == IDX_W'(i))) ent_q[i] <= wdata_i;
    end
  end

  assign rdata_o = ent_q[idx_i];
endmodule

// File: rtl/clus_dma_seq.sv
module clus_dma_seq
  import clus_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 3,
  parameter int BYTES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [IDX_W-1:0]  len_m1_i,
  input  logic              end_en_i,
  input  logic              gnt_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic              req_o,
  output logic              lock_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              end_o,
  output logic [IDX_W-1:0]  beat_o,
  output logic              buf_we_o,
  output logic              wb_o,
  output logic [ADDR_W-1:0] wb_src_o,
  output logic [ADDR_W-1:0] wb_dst_o,
  output logic [CNT_W-1:0]  wb_cnt_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BYTES);

  seq_st_e           st_q, st_d;
  logic [IDX_W-1:0]  beat_q;
  logic [ADDR_W-1:0] sptr_q, dptr_q;
  logic              last_beat, last_clus;

  assign last_beat = (beat_q == len_m1_i);
  assign last_clus = (cnt_i == CNT_W'(1));

  assign busy_o   = (st_q != ST_IDLE);
  assign req_o    = (st_q == ST_REQ) || (st_q == ST_RD) || (st_q == ST_WR);
  assign lock_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign rd_o     = (st_q == ST_RD);
  assign wr_o     = (st_q == ST_WR);
  assign addr_o   = rd_o ? sptr_q : dptr_q;
  assign end_o    = wr_o && last_beat && last_clus && end_en_i;
  assign beat_o   = beat_q;
  assign buf_we_o = rd_o && ack_i;
  assign wb_o     = wr_o && ack_i && last_beat;
  assign wb_src_o = sptr_q;
  assign wb_dst_o = dptr_q + STEP;
  assign wb_cnt_o = cnt_i - CNT_W'(1);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_REQ;
      ST_REQ:  if (gnt_i) st_d = ST_RD;
      ST_RD:   if (ack_i && last_beat) st_d = ST_WR;
      ST_WR:   if (ack_i && last_beat) st_d = last_clus ? ST_IDLE : ST_REL;
      ST_REL:  st_d = ST_REQ;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      sptr_q <= '0;
      dptr_q <= '0;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        ST_REQ: begin
          // pointers reload from the written-back registers each cluster
          sptr_q <= src_i;
          dptr_q <= dst_i;
          beat_q <= '0;
        end
        ST_RD: if (ack_i) begin
          sptr_q <= sptr_q + STEP;
          beat_q <= last_beat ? '0 : beat_q + 1'b1;
        end
        ST_WR: if (ack_i) begin
          dptr_q <= dptr_q + STEP;
          beat_q <= last_beat ? '0 : beat_q + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/clus_dma.sv
module clus_dma
  import clus_dma_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int DATA_W         = 32,
  parameter int CNT_W          = 16,
  parameter int MAX_CLUS_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_lock_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              end_pulse_o
);
  localparam int BYTES = DATA_W / 8;
  localparam int DEPTH = MAX_CLUS_BYTES / BYTES;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              busy, start, wb, buf_we, end_en;
  logic [ADDR_W-1:0] src, dst, wb_src, wb_dst;
  logic [CNT_W-1:0]  cnt, wb_cnt;
  logic [IDX_W-1:0]  len_m1, beat;

  clus_dma_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .busy_i   (busy),
    .wb_i     (wb),
    .wb_src_i (wb_src),
    .wb_dst_i (wb_dst),
    .wb_cnt_i (wb_cnt),
    .src_o    (src),
    .dst_o    (dst),
    .cnt_o    (cnt),
    .len_m1_o (len_m1),
    .end_en_o (end_en),
    .start_o  (start)
  );

  clus_dma_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .BYTES(BYTES)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .src_i    (src),
    .dst_i    (dst),
    .cnt_i    (cnt),
    .len_m1_i (len_m1),
    .end_en_i (end_en),
    .gnt_i    (bus_gnt_i),
    .ack_i    (mem_ack_i),
    .busy_o   (busy),
    .req_o    (bus_req_o),
    .lock_o   (bus_lock_o),
    .rd_o     (mem_rd_o),
    .wr_o     (mem_wr_o),
    .addr_o   (mem_addr_o),
    .end_o    (end_pulse_o),
    .beat_o   (beat),
    .buf_we_o (buf_we),
    .wb_o     (wb),
    .wb_src_o (wb_src),
    .wb_dst_o (wb_dst),
    .wb_cnt_o (wb_cnt)
  );

  clus_dma_buf #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_buf (
    .clk_i   (clk_i),
    .we_i    (buf_we),
    .idx_i   (beat),
    .wdata_i (mem_rdata_i),
    .rdata_o (mem_wdata_o)
  );
endmodule

// File: rtl/clus_dma_chk.sv
module clus_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic              bus_lock_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              end_pulse_o,
  input logic              busy
);
  a_r4_lock_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_lock_o |-> bus_gnt_i);

  a_r2_write_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_wr_o) |-> $past(mem_rd_o && mem_ack_i));

  a_r4_lock_until_last_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_lock_o) |-> $past(mem_wr_o && mem_ack_i));

  a_r5_release_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_lock_o) |-> !bus_req_o);

  a_r4_access_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_rd_o || mem_wr_o) && !mem_ack_i) |=>
      ($stable(mem_addr_o) && $stable(mem_rd_o) && $stable(mem_wr_o)));

  a_r3_read_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && mem_ack_i) |=>
      (!mem_rd_o || mem_addr_o == $past(mem_addr_o) + ADDR_W'(BYTES)));

  a_r3_write_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && mem_ack_i) |=>
      (!mem_wr_o || mem_addr_o == $past(mem_addr_o) + ADDR_W'(BYTES)));

  a_r7_end_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_pulse_o |-> (mem_wr_o && bus_lock_o));

  a_r8_busy_covers_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy);

  a_r2_no_dual_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
endmodule

bind clus_dma clus_dma_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_o   (bus_req_o),
  .bus_gnt_i   (bus_gnt_i),
  .bus_lock_o  (bus_lock_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o),
  .end_pulse_o (end_pulse_o),
  .busy        (busy)
);

// File: tb/clus_dma_bench.sv
module clus_dma_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        bus_req_o, bus_lock_o, mem_rd_o, mem_wr_o, end_pulse_o;
  logic        bus_gnt_i = 1'b0;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;

  logic [31:0] mem [1024];
  assign mem_rdata_i = mem[mem_addr_o[11:2]];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  clus_dma u_clus_dma (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .bus_lock_o(bus_lock_o),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
    .end_pulse_o(end_pulse_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus environment: random grant latency and wait states
  always @(posedge clk_i) begin
    #1;
    bus_gnt_i = bus_req_o ? (bus_gnt_i || ($urandom_range(0, 1) == 1)) : 1'b0;
    mem_ack_i = ($urandom_range(0, 3) != 0);
  end

  // monitor state
  int          mon_len = 1;
  logic [31:0] exp_src_a, exp_dst_a, last_dst_a;
  logic [31:0] rdq [8];
  int          rd_cnt = 0, wr_cnt = 0, ten_cnt = 0, end_cnt = 0, req_cnt = 0;
  bit          prev_lock = 0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (bus_req_o) req_cnt++;
      if ((mem_rd_o || mem_wr_o) && !bus_lock_o)
        chk(0, "R4", "access without lock", {30'd0, mem_rd_o, mem_wr_o}, 0);
      if (mem_rd_o && mem_ack_i) begin
        if (wr_cnt != 0) chk(0, "R2", "read after write in cluster", wr_cnt, 0);
        chk(mem_addr_o == exp_src_a, "R3", "read address", mem_addr_o, exp_src_a);
        if (rd_cnt < 8) rdq[rd_cnt] = mem_rdata_i;
        rd_cnt++;
        exp_src_a += 4;
      end
      if (mem_wr_o && mem_ack_i) begin
        chk(mem_addr_o == exp_dst_a, "R3", "write address", mem_addr_o, exp_dst_a);
        if (wr_cnt < 8)
          chk(mem_wdata_o == rdq[wr_cnt], "R2", "write data", mem_wdata_o, rdq[wr_cnt]);
        mem[mem_addr_o[11:2]] = mem_wdata_o;
        if (end_pulse_o) begin
          end_cnt++;
          chk(mem_addr_o == last_dst_a, "R7", "end pulse beat", mem_addr_o, last_dst_a);
        end
        wr_cnt++;
        exp_dst_a += 4;
      end
      if (prev_lock && !bus_lock_o) begin
        chk(rd_cnt == mon_len && wr_cnt == mon_len, (mon_len == 1) ? "R10" : "R2",
            "beats per tenure", (rd_cnt << 8) | wr_cnt, (mon_len << 8) | mon_len);
        chk(!bus_req_o, "R5", "request dropped after cluster", bus_req_o, 0);
        ten_cnt++;
        rd_cnt = 0;
        wr_cnt = 0;
      end
      prev_lock = bus_lock_o;
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk_i); #1;
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk_i); #1;
    cfg_addr_i = a;
    @(negedge clk_i);
    d = cfg_rdata_o;
  endtask

  function automatic logic [31:0] ctl_word(input int len, input bit en, input bit go);
    return (32'(len - 1) << 4) | (32'(en) << 1) | 32'(go);
  endfunction

  task automatic run_xfer(input int sw, input int dw, input int len, input int cnt,
                          input bit en, input bit poke);
    logic [31:0] v;
    int words = len * cnt;
    int bad = 0;
    int waited = 0;
    for (int k = 0; k < words; k++) mem[sw + k] = $urandom;
    for (int k = 0; k <= words; k++) mem[dw + k] = 32'hDEAD_BEEF;
    mon_len = len; exp_src_a = sw * 4; exp_dst_a = dw * 4;
    last_dst_a = (dw + words - 1) * 4;
    ten_cnt = 0; end_cnt = 0; rd_cnt = 0; wr_cnt = 0;
    wr_reg(2'd0, sw * 4);
    wr_reg(2'd1, dw * 4);
    wr_reg(2'd2, cnt);
    wr_reg(2'd3, ctl_word(len, en, 1'b1));
    rd_reg(2'd3, v);
    chk(v[8] == 1'b1, "R8", "busy after start", v[8], 1);
    if (poke) begin
      wr_reg(2'd0, 32'h40);
      wr_reg(2'd2, 32'd99);
      wr_reg(2'd3, ctl_word(8, !en, 1'b1));
    end
    do begin
      rd_reg(2'd3, v);
      waited++;
    end while (v[8] && waited < 20000);
    chk(v[8] == 1'b0, "R8", "busy clears", v[8], 0);
    chk(v[6:4] == 3'(len - 1) && v[1] == en, "R1", "control readback",
        v, ctl_word(len, en, 1'b0));
    rd_reg(2'd0, v);
    chk(v == (sw + words) * 4, "R3", "source writeback", v, (sw + words) * 4);
    rd_reg(2'd1, v);
    chk(v == (dw + words) * 4, "R3", "destination writeback", v, (dw + words) * 4);
    rd_reg(2'd2, v);
    chk(v == 0, "R6", "count at end", v, 0);
    chk(ten_cnt == cnt, "R6", "cluster tenures", ten_cnt, cnt);
    chk(end_cnt == int'(en), "R7", "end pulses", end_cnt, en);
    for (int k = 0; k < words; k++) if (mem[dw + k] != mem[sw + k]) bad++;
    chk(bad == 0, "R2", "copied words mismatching", bad, 0);
    chk(mem[dw + words] == 32'hDEAD_BEEF, "R1", "guard word", mem[dw + words], 32'hDEAD_BEEF);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), v);
      chk(v == 0, "R11", "register after reset", v, 0);
    end
    chk({bus_req_o, bus_lock_o, mem_rd_o, mem_wr_o, end_pulse_o} == 5'd0,
        "R11", "bus outputs after reset",
        {bus_req_o, bus_lock_o, mem_rd_o, mem_wr_o, end_pulse_o}, 0);
    // zero count start ignored
    req_cnt = 0;
    wr_reg(2'd3, ctl_word(4, 1'b1, 1'b1));
    rd_reg(2'd3, v);
    chk(v[8] == 1'b0, "R9", "busy on zero count", v[8], 0);
    repeat (20) @(posedge clk_i);
    chk(req_cnt == 0, "R9", "requests on zero count", req_cnt, 0);
    // directed corners
    run_xfer(16, 600, 1, 3, 1'b1, 1'b0);   // R10 single-access clusters
    run_xfer(40, 520, 8, 2, 1'b0, 1'b0);   // R1 full 32-byte cluster
    run_xfer(100, 640, 4, 3, 1'b1, 1'b1);  // R8 writes while busy
    // random runs
    for (int i = 0; i < 12; i++)
      run_xfer($urandom_range(0, 190), $urandom_range(512, 700),
               $urandom_range(1, 8), $urandom_range(1, 8),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule